// File: doc/BRIEF.md
# Character Blink Phase Generator

This block sets the rhythm for blinking characters in an on-screen text overlay. It counts the rising edges of the vertical sync input. The count runs over a blink period of 32 or 64 frames, and `period_long` picks which. In each period the early part is visible. Once the count reaches a threshold set by the duty selection, the rest of the period is the hidden phase, and `blink_off` is high during it.

The display pipeline gives the blink attribute bit of the character cell it is drawing to `cell_blink`. It then uses `fg_enable` to gate the foreground pixels of that glyph. The background colour of the cell is not part of this gating, so it keeps showing through the hidden phase. Blinking stops in either of two cases: `blink_en` is low, or the duty selection is zero. In both cases every character stays visible.

The vertical sync input is asynchronous to the pixel-domain clock and is synchronised inside the block. The reset input asserts asynchronously and is released in step with the clock.

Top module: `blink_phase_gen`

## Requirements
- R1: When reset is released, `blink_off` is 0, `fg_enable` is 1 and the frame count is zero.
- R2: With `period_long`=0 the frame count runs 0..31 and wraps to 0. With `period_long`=1 it runs 0..63 and wraps to 0.
- R3: Let P be the period (32 or 64) and D the value of `duty_sel` (1, 2 or 3). Then `blink_off` is 1 exactly while the frame count is at or above D*P/4. D=1 gives 25% visible time, D=2 gives 50% and D=3 gives 75%.
- R4: With `duty_sel`=0, `blink_off` stays 0 at every frame count.
- R5: The frame count advances by one for each rising edge of `vsync_in`. A sync level held high for several clocks counts once.
- R6: Any change of `period_long` restarts the frame count from zero on the next clock.
- R7: While `blink_en` is 0, `blink_off` is 0 and the frame count is held at zero, so sync edges are ignored. Counting resumes from zero once `blink_en` returns to 1.
- R8: `fg_enable` is 0 only when `cell_blink` is 1 and `blink_off` is 1. With `cell_blink`=0 it stays 1 in every phase.
- R9: `vsync_in` passes through SYNC_STAGES synchronising flops and one edge register. With the default of 2 stages, a new count is visible at the outputs from the third rising clock edge after `vsync_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| vsync_in | input | 1 | Vertical sync, active high, asynchronous |
| blink_en | input | 1 | Master blink enable |
| period_long | input | 1 | 0 selects 32 frames, 1 selects 64 frames |
| duty_sel | input | 2 | 0 off, 1/2/3 visible for one, two or three quarters |
| cell_blink | input | 1 | Blink attribute of the cell being drawn |
| blink_off | output | 1 | High during the hidden phase |
| fg_enable | output | 1 | Foreground gate for the current cell |

## Verification
The bench sweeps every count through a full period and one step past the wrap, for both periods and all four duty values. A wrong threshold product or an off-by-one comparison would move the hidden/visible boundary by one frame. A bad wrap limit would make a 32-frame period run on into 64. The bench also switches the period in the middle of a count and drops the enable during the hidden phase. A design that forgot the restart, or kept counting while disabled, would show the wrong phase after the switch. Sync pulses are held high for several clocks, which catches level-sensitive counting. The bench also applies `cell_blink` low in the hidden phase, which catches gating that ignores the attribute.

// File: rtl/blink_pkg.sv
package blink_pkg;

  typedef enum logic [1:0] {
    DUTY_OFF = 2'd0,
    DUTY_Q1  = 2'd1,
    DUTY_Q2  = 2'd2,
    DUTY_Q3  = 2'd3
  } duty_e;

  // hidden-phase threshold: duty quarters times a quarter period
  function automatic logic [7:0] quarter_mult(input logic [7:0] quarter,
                                              input duty_e d);
    logic [7:0] r;
    case (d)
      DUTY_Q1: r = quarter;
      DUTY_Q2: r = quarter << 1;
      DUTY_Q3: r = quarter + (quarter << 1);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/blink_rst_sync.sv
module blink_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];

endmodule

// File: rtl/blink_vs_edge.sv
module blink_vs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], vsync_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R5: a detected edge lasts a single cycle
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/blink_frame_ctr.sv
module blink_frame_ctr #(
  parameter int BASE_LOG = 5,
  localparam int CW = BASE_LOG + 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          en_i,
  input  logic          period_long_i,
  output logic [CW-1:0] cnt_o,
  output logic          long_o
);

  localparam logic [CW-1:0] LAST_SHORT = CW'((1 << BASE_LOG) - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'((1 << CW) - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;
  logic [CW-1:0] last;
  logic          restart;

  always_comb begin
    last    = long_q ? LAST_LONG : LAST_SHORT;
    restart = !en_i || (period_long_i != long_q);
    long_d  = period_long_i;
    cnt_d   = cnt_q;
    if (restart)          cnt_d = '0;
    else if (rise_i) begin
      if (cnt_q == last)  cnt_d = '0;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign long_o = long_q;

  // R2: the count never passes the last value of the selected period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= last);

  // R5: the count only steps by one or returns to zero
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  // R6: a period change restarts the count
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    (period_long_i != long_q) |=> (cnt_q == '0));

  // R7: disabled means held at zero
  a_r7_held: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/blink_phase_gen.sv
module blink_phase_gen
  import blink_pkg::*;
#(
  parameter int BASE_LOG    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CW = BASE_LOG + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_in,
  input  logic       blink_en,
  input  logic       period_long,
  input  logic [1:0] duty_sel,
  input  logic       cell_blink,
  output logic       blink_off,
  output logic       fg_enable
);

  localparam logic [7:0] QTR_SHORT = 8'((1 << BASE_LOG) >> 2);
  localparam logic [7:0] QTR_LONG  = 8'((1 << CW) >> 2);

  logic          rst_int_n;
  logic          vs_rise;
  logic [CW-1:0] cnt;
  logic          long_q;
  logic [7:0]    thresh;
  logic          hide;
  duty_e         duty;

  blink_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  blink_vs_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .vsync_i (vsync_in),
    .rise_o  (vs_rise)
  );

  blink_frame_ctr #(.BASE_LOG(BASE_LOG)) u_ctr (
    .clk           (clk),
    .rst_ni        (rst_int_n),
    .rise_i        (vs_rise),
    .en_i          (blink_en),
    .period_long_i (period_long),
    .cnt_o         (cnt),
    .long_o        (long_q)
  );

  always_comb begin
    duty   = duty_e'(duty_sel);
    thresh = quarter_mult(long_q ? QTR_LONG : QTR_SHORT, duty);
    hide   = blink_en && (duty != DUTY_OFF) && (8'(cnt) >= thresh);
  end

  assign blink_off = hide;
  assign fg_enable = !(cell_blink && hide);

  // R7: disabled blinking never hides
  a_r7_no_hide: assert property (@(posedge clk) disable iff (!rst_int_n)
    !blink_en |-> !blink_off);

  // R4: duty zero never hides
  a_r4_duty_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    (duty_sel == 2'd0) |-> !blink_off);

  // R8: cells without the attribute are always drawn
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cell_blink |-> fg_enable);

  // R3: count zero is always in the visible phase
  a_r3_zero_visible: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cnt == '0) |-> !blink_off);

endmodule

// File: tb/blink_phase_gen_tb.sv
module blink_phase_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync_in = 1'b0;
  logic       blink_en = 1'b0;
  logic       period_long = 1'b0;
  logic [1:0] duty_sel = 2'd0;
  logic       cell_blink = 1'b0;
  logic       blink_off;
  logic       fg_enable;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blink_phase_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_in    (vsync_in),
    .blink_en    (blink_en),
    .period_long (period_long),
    .duty_sel    (duty_sel),
    .cell_blink  (cell_blink),
    .blink_off   (blink_off),
    .fg_enable   (fg_enable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sync pulse held for four clocks, then settled
  task automatic pulse();
    @(negedge clk) vsync_in = 1'b1;
    repeat (4) @(negedge clk);
    vsync_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic bit exp_hide(input int cnt, input int p, input int d, input bit en);
    return en && d != 0 && cnt >= d * p / 4;
  endfunction

  task automatic check_phase(input int cnt, input int p, input int d, input string req);
    bit eh;
    eh = exp_hide(cnt, p, d, blink_en);
    cell_blink = 1'b1;
    #1;
    check(blink_off == eh, req, blink_off, eh);
    check(fg_enable == !eh, "R8", fg_enable, !eh);
    cell_blink = 1'b0;
    #1;
    check(fg_enable == 1'b1, "R8", fg_enable, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    #1;
    check(blink_off == 1'b0, "R1", blink_off, 0);
    cell_blink = 1'b1;
    #1;
    check(fg_enable == 1'b1, "R1", fg_enable, 1);
    cell_blink = 1'b0;

    // sweep: both periods, all duties, through one wrap (R2 R3 R4 R5)
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 4; d++) begin
        int per;
        per = p ? 64 : 32;
        @(negedge clk);
        blink_en = 1'b0;
        period_long = p[0];
        duty_sel = d[1:0];
        repeat (2) @(negedge clk);
        blink_en = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= per; k++) begin
          check_phase(k % per, per, d, d == 0 ? "R4" : (k == per ? "R2" : "R3"));
          pulse();
        end
      end
    end

    // R9: count not yet visible two clocks after the edge, visible after three
    @(negedge clk);
    blink_en = 1'b0; period_long = 1'b0; duty_sel = 2'd3;
    @(negedge clk); blink_en = 1'b1;
    for (int k = 0; k < 23; k++) pulse();
    #1; check(blink_off == 1'b0, "R9", blink_off, 0);
    @(negedge clk) vsync_in = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    check(blink_off == 1'b0, "R9", blink_off, 0);
    @(posedge clk); #2;
    check(blink_off == 1'b1, "R9", blink_off, 1);
    @(negedge clk) vsync_in = 1'b0;
    repeat (4) @(negedge clk);

    // R6: restart on period change
    duty_sel = 2'd2;
    #1; check(blink_off == 1'b1, "R6", blink_off, 1);
    @(negedge clk) period_long = 1'b1;
    @(negedge clk); #1;
    check(blink_off == 1'b0, "R6", blink_off, 0);
    for (int k = 0; k < 31; k++) pulse();
    check_phase(31, 64, 2, "R6");
    pulse();
    check_phase(32, 64, 2, "R6");

    // R7: disable during hidden phase, edges ignored, resume from zero
    @(negedge clk) blink_en = 1'b0;
    #1; check(blink_off == 1'b0, "R7", blink_off, 0);
    for (int k = 0; k < 40; k++) pulse();
    check(blink_off == 1'b0, "R7", blink_off, 0);
    blink_en = 1'b1;
    @(negedge clk); #1;
    check(blink_off == 1'b0, "R7", blink_off, 0);
    for (int k = 0; k < 32; k++) pulse();
    check_phase(32, 64, 2, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule